// File: doc/BRIEF.md
# Banked Level-Sensitive Interrupt Controller

This block gathers 72 level-sensitive interrupt lines into three banks and raises one interrupt request towards the processor. Bank 0 holds 8 local lines. Banks 1 and 2 hold 32 peripheral lines each. Every line has an enable bit. A line is pending while its input is high and its enable is set. Pending bits follow the input level and hold no memory of earlier activity.

Software sees a small 32-bit register port. Each bank has three registers:

- an enable-set register, where 1 bits turn enables on;
- an enable-clear register, where 1 bits turn enables off;
- a raw pending register.

A summary register reports the 8 local lines directly. It also carries one "something pending" flag for each peripheral bank, and shortcut copies of a fixed group of bank-1 and bank-2 lines. In most cases a single read of the summary register tells the handler which source needs service.

Addresses are byte offsets and must be word aligned. Within each register group, bank n sits 4 bytes above bank 0. Reads are registered: `rdata` takes the selected value at the clock edge where `rd_en` is high, and keeps it while `rd_en` is low.

Top module: `banked_irq_ctrl`

## Requirements
- R1: After reset every enable is 0, `irq` is low, and the summary, pending and enable registers all read 0.
- R2: A write to enable-set address 0x10+4n (n = bank 0..2) sets the enables of bank n where the data bit is 1. Data bits that are 0 leave their enables unchanged.
- R3: A write to enable-clear address 0x1C+4n clears the enables of bank n where the data bit is 1. Data bits that are 0 leave their enables unchanged.
- R4: A read of either the enable-set or the enable-clear address of bank n returns that bank's current enable mask. Bits above the bank width (bits 31:8 for bank 0) read 0.
- R5: The raw pending register of bank n, at 0x04+4n, reads the input level AND the enable for each line. A line whose input falls reads 0 again, with no latching.
- R6: Summary register bits 7:0, at offset 0x00, equal the pending bits of bank 0.
- R7: Summary bit 8 is 1 when any bank-1 line is pending. Summary bit 9 is 1 when any bank-2 line is pending.
- R8: Summary bits 14:10 copy the pending bits of bank-1 lines 7..11. Summary bits 20:15 copy the pending bits of bank-2 lines 21..26. Summary bits 31:21 read 0.
- R9: `irq` is the OR of every pending bit across all three banks, and it follows the inputs without a clock delay.
- R10: A write to a misaligned address, or to any address at or above 0x28, changes no enable. A read of such an address returns 0.
- R11: `rdata` is loaded only at a clock edge where `rd_en` is 1. It holds its value in cycles where `rd_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_lvl | input | 72 | Source levels: bits 7:0 are bank 0, bits 39:8 are bank 1, bits 71:40 are bank 2 |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq | output | 1 | Interrupt request to the processor |

## Verification
The bench builds the block with its default parameters: an 8-line local bank, two 32-line peripheral banks, and shortcut windows starting at bank-1 line 7 and bank-2 line 21. These values put the narrow bank-0 enable register in reach, where writes of all ones must read back truncated to 8 bits. They also reach the top bit of bank 2 just outside its shortcut window, and the full-width enables of the peripheral banks. A bench model of enables and levels predicts every summary, pending and request value. It checks those predictions across several source patterns, around writes of zero, and around writes to addresses the map does not decode.

// File: rtl/birq_pkg.sv
package birq_pkg;

  localparam int DATA_W = 32;
  localparam int ADDR_W = 8;
  localparam int NBANK  = 3;

  typedef enum logic [2:0] {
    RK_NONE,
    RK_SUMMARY,
    RK_PEND,
    RK_ENSET,
    RK_ENCLR
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e  kind;
    logic [1:0] bank;
  } reg_sel_t;

  // Word 0: summary; words 1-3: pending; words 4-6: enable set; words 7-9: enable clear.
  function automatic reg_sel_t decode_addr(input logic [ADDR_W-1:0] a);
    reg_sel_t   s;
    logic [5:0] w;
    s.kind = RK_NONE;
    s.bank = 2'd0;
    w      = a[ADDR_W-1:2];
    if (a[1:0] == 2'b00) begin
      if (w == 6'd0) begin
        s.kind = RK_SUMMARY;
      end else if (w <= 6'd3) begin
        s.kind = RK_PEND;
        s.bank = 2'(w - 6'd1);
      end else if (w <= 6'd6) begin
        s.kind = RK_ENSET;
        s.bank = 2'(w - 6'd4);
      end else if (w <= 6'd9) begin
        s.kind = RK_ENCLR;
        s.bank = 2'(w - 6'd7);
      end
    end
    return s;
  endfunction

endpackage

// File: rtl/birq_bank.sv
module birq_bank #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_we,
  input  logic             clr_we,
  input  logic [WIDTH-1:0] wbits,
  input  logic [WIDTH-1:0] level,
  output logic [WIDTH-1:0] en_mask,
  output logic [WIDTH-1:0] pend
);

  function automatic logic [WIDTH-1:0] next_enable(
    input logic [WIDTH-1:0] cur,
    input logic [WIDTH-1:0] bits,
    input logic             do_set
  );
    return do_set ? (cur | bits) : (cur & ~bits);
  endfunction

  logic [WIDTH-1:0] en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (set_we || clr_we) begin
      en_q <= next_enable(en_q, wbits, set_we);
    end
  end

  assign en_mask = en_q;
  assign pend    = level & en_q;

endmodule

// File: rtl/birq_summary.sv
module birq_summary #(
  parameter int LOCAL_N  = 8,
  parameter int PERIPH_N = 32,
  parameter int SC1_BASE = 7,
  parameter int SC1_N    = 5,
  parameter int SC2_BASE = 21,
  parameter int SC2_N    = 6
) (
  input  logic [LOCAL_N-1:0]  pend0,
  input  logic [PERIPH_N-1:0] pend1,
  input  logic [PERIPH_N-1:0] pend2,
  output logic [31:0]         summary
);

  localparam int FLAG1   = LOCAL_N;
  localparam int FLAG2   = LOCAL_N + 1;
  localparam int SC1_LSB = LOCAL_N + 2;
  localparam int SC2_LSB = SC1_LSB + SC1_N;

  always_comb begin
    summary                   = '0;
    summary[LOCAL_N-1:0]      = pend0;
    summary[FLAG1]            = |pend1;
    summary[FLAG2]            = |pend2;
    summary[SC1_LSB +: SC1_N] = pend1[SC1_BASE +: SC1_N];
    summary[SC2_LSB +: SC2_N] = pend2[SC2_BASE +: SC2_N];
  end

endmodule

// File: rtl/birq_readmux.sv
module birq_readmux
  import birq_pkg::*;
(
  input  reg_sel_t                     sel,
  input  logic [31:0]                  summary,
  input  logic [NBANK-1:0][DATA_W-1:0] pend_arr,
  input  logic [NBANK-1:0][DATA_W-1:0] en_arr,
  output logic [DATA_W-1:0]            rd_value
);

  always_comb begin
    case (sel.kind)
      RK_SUMMARY:        rd_value = summary;
      RK_PEND:           rd_value = pend_arr[sel.bank];
      RK_ENSET, RK_ENCLR: rd_value = en_arr[sel.bank];
      default:           rd_value = '0;
    endcase
  end

endmodule

// File: rtl/banked_irq_ctrl.sv
module banked_irq_ctrl
  import birq_pkg::*;
#(
  parameter int LOCAL_N  = 8,
  parameter int PERIPH_N = 32,
  parameter int SC1_BASE = 7,
  parameter int SC1_N    = 5,
  parameter int SC2_BASE = 21,
  parameter int SC2_N    = 6,
  localparam int NSRC    = LOCAL_N + 2 * PERIPH_N
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_lvl,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);

  reg_sel_t                     sel;
  logic [NBANK-1:0]             set_we;
  logic [NBANK-1:0]             clr_we;
  logic [NBANK-1:0][DATA_W-1:0] en_arr;
  logic [NBANK-1:0][DATA_W-1:0] pend_arr;
  logic [31:0]                  summary;
  logic [DATA_W-1:0]            rd_value;

  assign sel = decode_addr(addr);

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    localparam int W   = (b == 0) ? LOCAL_N : PERIPH_N;
    localparam int OFF = (b == 0) ? 0 : LOCAL_N + (b - 1) * PERIPH_N;

    logic [W-1:0] en_w;
    logic [W-1:0] pend_w;

    assign set_we[b] = wr_en && (sel.kind == RK_ENSET) && (sel.bank == 2'(b));
    assign clr_we[b] = wr_en && (sel.kind == RK_ENCLR) && (sel.bank == 2'(b));

    birq_bank #(.WIDTH(W)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_we  (set_we[b]),
      .clr_we  (clr_we[b]),
      .wbits   (wdata[W-1:0]),
      .level   (src_lvl[OFF +: W]),
      .en_mask (en_w),
      .pend    (pend_w)
    );

    assign en_arr[b]   = DATA_W'(en_w);
    assign pend_arr[b] = DATA_W'(pend_w);
  end

  birq_summary #(
    .LOCAL_N  (LOCAL_N),
    .PERIPH_N (PERIPH_N),
    .SC1_BASE (SC1_BASE),
    .SC1_N    (SC1_N),
    .SC2_BASE (SC2_BASE),
    .SC2_N    (SC2_N)
  ) u_summary (
    .pend0   (pend_arr[0][LOCAL_N-1:0]),
    .pend1   (pend_arr[1][PERIPH_N-1:0]),
    .pend2   (pend_arr[2][PERIPH_N-1:0]),
    .summary (summary)
  );

  birq_readmux u_readmux (
    .sel      (sel),
    .summary  (summary),
    .pend_arr (pend_arr),
    .en_arr   (en_arr),
    .rd_value (rd_value)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (rd_en) begin
      rdata <= rd_value;
    end
  end

  assign irq = |pend_arr;

endmodule

// File: rtl/birq_checker.sv
module birq_checker
  import birq_pkg::*;
#(
  parameter int LOCAL_N  = 8,
  parameter int PERIPH_N = 32,
  localparam int NSRC    = LOCAL_N + 2 * PERIPH_N
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     rd_en,
  input logic [DATA_W-1:0]        wdata,
  input logic [DATA_W-1:0]        rdata,
  input logic [NSRC-1:0]          src_lvl,
  input logic                     irq,
  input logic [NBANK-1:0]         set_we,
  input logic [NBANK-1:0]         clr_we,
  input logic [NBANK-1:0][DATA_W-1:0] en_arr,
  input logic [NBANK-1:0][DATA_W-1:0] pend_arr,
  input logic [31:0]              summary
);

  assert_reset_quiet_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> (en_arr == '0) && !irq);

  for (genvar b = 0; b < NBANK; b++) begin : g_chk
    localparam int W   = (b == 0) ? LOCAL_N : PERIPH_N;
    localparam int OFF = (b == 0) ? 0 : LOCAL_N + (b - 1) * PERIPH_N;
    localparam logic [31:0] BM = (32'd1 << W) - 32'd1;

    assert_set_ones_R2: assert property (@(posedge clk) disable iff (!rst_n)
      set_we[b] |=> ((en_arr[b] & $past(wdata)) == ($past(wdata) & BM)));

    assert_set_zeros_keep_R2: assert property (@(posedge clk) disable iff (!rst_n)
      set_we[b] |=> ((en_arr[b] & ~$past(wdata)) == ($past(en_arr[b]) & ~$past(wdata))));

    assert_clr_ones_R3: assert property (@(posedge clk) disable iff (!rst_n)
      clr_we[b] |=> ((en_arr[b] & $past(wdata)) == '0));

    assert_clr_zeros_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
      clr_we[b] |=> ((en_arr[b] & ~$past(wdata)) == ($past(en_arr[b]) & ~$past(wdata))));

    assert_pend_needs_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_arr[b] & ~(32'(src_lvl[OFF +: W]))) == '0);
  end

  assert_bank_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (summary[LOCAL_N] == (pend_arr[1] != '0)) && (summary[LOCAL_N+1] == (pend_arr[2] != '0)));

  assert_irq_from_summary_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (summary[LOCAL_N+1:0] != '0));

  assert_no_stray_enable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (set_we == '0) && (clr_we == '0) |=> $stable(en_arr));

  assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));

endmodule

bind banked_irq_ctrl birq_checker #(
  .LOCAL_N  (LOCAL_N),
  .PERIPH_N (PERIPH_N)
) u_birq_checker (.*);

// File: tb/test_banked_irq_ctrl.sv
module test_banked_irq_ctrl;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [71:0] src = '0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;

  logic [31:0] m_en [3];

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } sb_item_t;

  sb_item_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  banked_irq_ctrl i_banked_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .src_lvl(src), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] lvl(input int b);
    if (b == 0) return {24'd0, src[7:0]};
    if (b == 1) return src[39:8];
    return src[71:40];
  endfunction

  function automatic logic [31:0] pend_exp(input int b);
    return lvl(b) & m_en[b];
  endfunction

  function automatic logic [31:0] sum_exp();
    logic [31:0] s;
    logic [31:0] p0, p1, p2;
    p0 = pend_exp(0);
    p1 = pend_exp(1);
    p2 = pend_exp(2);
    s = '0;
    for (int i = 0; i < 8; i++) s[i] = p0[i];
    s[8] = (p1 != 0);
    s[9] = (p2 != 0);
    for (int i = 0; i < 5; i++) s[10+i] = p1[7+i];
    for (int i = 0; i < 6; i++) s[15+i] = p2[21+i];
    return s;
  endfunction

  function automatic logic irq_exp();
    return (pend_exp(0) | pend_exp(1) | pend_exp(2)) != 0;
  endfunction

  // Driver: issue a read and queue the value it must return.
  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    addr  = a;
    rd_en = 1'b1;
    sb_q.push_back('{exp, tag});
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  // Monitor: compare returned data one step after the capturing edge.
  always @(posedge clk) begin
    sb_item_t it;
    if (rd_en) begin
      #1;
      it = sb_q.pop_front();
      check(it.tag, rdata, it.exp);
    end
  end

  task automatic wr_raw(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr  = a;
    wdata = d;
    wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wr_set(input int b, input logic [31:0] d);
    wr_raw(8'(8'h10 + 4*b), d);
    m_en[b] = m_en[b] | (b == 0 ? (d & 32'hFF) : d);
  endtask

  task automatic wr_clr(input int b, input logic [31:0] d);
    wr_raw(8'(8'h1C + 4*b), d);
    m_en[b] = m_en[b] & ~d;
  endtask

  task automatic drive_src(input logic [71:0] v, input string tag);
    @(negedge clk);
    src = v;
    #1;
    check(tag, {31'd0, irq}, {31'd0, irq_exp()});
  endtask

  task automatic read_all(input string tag);
    rd(8'h00, sum_exp(), {tag, " summary"});
    for (int b = 0; b < 3; b++) begin
      rd(8'(8'h04 + 4*b), pend_exp(b), {tag, " pending"});
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    logic [31:0] held;
    for (int b = 0; b < 3; b++) m_en[b] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    #1;
    check("R1 irq after reset", {31'd0, irq}, 32'd0);
    check("R1 rdata after reset", rdata, 32'd0);
    rd(8'h00, 32'd0, "R1 summary after reset");
    rd(8'h10, 32'd0, "R1 bank0 enables after reset");
    rd(8'h24, 32'd0, "R1 bank2 enables after reset");

    // R9: all lines high but nothing enabled
    drive_src({72{1'b1}}, "R9 irq with no enables");
    rd(8'h08, 32'd0, "R5 bank1 pending with enables off");

    // R2 / R4 / R8: enable the bank-1 shortcut lines
    wr_set(1, 32'h0000_0F80);
    rd(8'h14, 32'h0000_0F80, "R4 bank1 enables via set address");
    rd(8'h20, 32'h0000_0F80, "R4 bank1 enables via clear address");
    read_all("R8 bank1 shortcuts");
    #1 check("R9 irq with bank1 enabled", {31'd0, irq}, 32'd1);

    // R2: zero data changes nothing
    wr_set(1, 32'h0);
    rd(8'h14, 32'h0000_0F80, "R2 set with zero data");

    // R3: clear with ones and with zeros
    wr_clr(1, 32'h0000_0080);
    rd(8'h14, 32'h0000_0F00, "R3 clear one bit");
    wr_clr(1, 32'h0);
    rd(8'h20, 32'h0000_0F00, "R3 clear with zero data");

    // R4: narrow bank truncates to 8 bits
    wr_set(0, 32'hFFFF_FFFF);
    rd(8'h10, 32'h0000_00FF, "R4 bank0 enable width");

    // R6 / R7 / R8: several source patterns
    wr_set(2, 32'h87E0_0000);
    drive_src({32'h8420_0000, 32'h0000_0A00, 8'hA5}, "R9 pattern A");
    read_all("R6 R7 R8 pattern A");
    drive_src({32'h8000_0000, 32'h0000_0000, 8'h00}, "R9 pattern B");
    read_all("R7 pattern B bank2 outside shortcut");
    drive_src({32'h0000_0000, 32'h0000_0100, 8'h3C}, "R9 pattern C");
    read_all("R6 R8 pattern C");

    // R5: level not latched
    drive_src({32'h0420_0000, 32'h0, 8'h00}, "R5 level high");
    rd(8'h0C, 32'h0420_0000, "R5 bank2 pending high");
    drive_src(72'd0, "R5 level dropped irq");
    rd(8'h0C, 32'h0, "R5 bank2 pending after drop");
    rd(8'h00, 32'h0, "R5 summary after drop");

    // R10: undecoded writes and reads
    wr_raw(8'h1D, 32'hFFFF_FFFF);
    wr_raw(8'h28, 32'hFFFF_FFFF);
    wr_raw(8'h30, 32'hFFFF_FFFF);
    rd(8'h10, m_en[0], "R10 bank0 enables unchanged");
    rd(8'h14, m_en[1], "R10 bank1 enables unchanged");
    rd(8'h18, m_en[2], "R10 bank2 enables unchanged");
    rd(8'h28, 32'h0, "R10 read beyond map");
    rd(8'h13, 32'h0, "R10 misaligned read");

    // R11: rdata holds without rd_en
    drive_src({32'h0, 32'h0, 8'hFF}, "R9 bank0 all high");
    rd(8'h04, 32'h0000_00FF, "R11 capture bank0 pending");
    held = 32'h0000_00FF;
    drive_src(72'd0, "R9 bank0 dropped");
    @(negedge clk);
    check("R11 rdata held without read", rdata, held);

    // R3 / R9: clear everything
    drive_src({72{1'b1}}, "R9 all high with enables");
    wr_clr(0, 32'hFFFF_FFFF);
    wr_clr(1, 32'hFFFF_FFFF);
    wr_clr(2, 32'hFFFF_FFFF);
    #1 check("R9 irq after clearing all", {31'd0, irq}, 32'd0);
    rd(8'h00, 32'h0, "R3 summary after clearing all");

    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule